// File: doc/BRIEF.md
# Static Clock Mode Controller

This block turns one fast reference clock into a family of related system clocks that can run at full rate, run at a much lower rate, or halt entirely and resume later. All of its logic is clocked by the reference, so every output edge lands on a reference edge. The only exception is the falling edge of the 50% clock in fast mode, which lands on a reference falling edge. The main system clock is high for one third of each period. A companion clock of the same frequency is high for half of each period and rises together with the main clock. A peripheral clock runs at half the system frequency.

Software stops the clocks by placing the processor in its halt state. The block watches three status lines and recognises the halt code on each rising system clock edge. It lets the current period finish and then holds every clock low. A start request brings the clocks back, and the first period after restart has full length. The rate select is applied only at period boundaries, so every visible pulse has full length. The reset input is active low and asynchronous. Its release must be synchronous to the reference clock.

Top module: `sclk_mode_ctrl`

## Requirements
- R1: With the active rate fast, each system clock period lasts 3 reference cycles and the system clock is high for 1 of them.
- R2: With the active rate slow, each system clock period lasts 768 reference cycles and the system clock is high for 256 of them.
- R3: The 50% clock rises on the same reference edge as the system clock. It stays high for half of the period: 1.5 reference cycles in fast mode, where it falls on a reference falling edge, and 384 reference cycles in slow mode.
- R4: The peripheral clock toggles on every falling edge of the system clock and at no other time.
- R5: When the status lines read the halt code (bit 2 = 0, bit 1 = 1, bit 0 = 1) at the reference edge where the system clock rises, the current period completes normally. On its last reference edge, running drops and all system clocks stay low from then on.
- R6: Any other status code at a system clock rising edge does not stop the clocks, and the next period follows without a gap.
- R7: A start request seen while stopped raises running at that reference edge. The system clock rises on the next reference edge and begins a full period. While the block is stopped with no start request, it stays stopped. A start request while running has no effect.
- R8: The rate of a period is the value of the rate select (1 = slow) at the reference edge just before that period's first rising edge. A change in the middle of a period never shortens or stretches a pulse.
- R9: While reset is asserted, the system, 50% and peripheral clocks are low, running is high, and the active rate is fast.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| slow_sel | input | 1 | Rate select: 1 = slow (divide by 768), 0 = fast (divide by 3) |
| stat_i | input | 3 | Processor status lines; 3'b011 means halt |
| start_req | input | 1 | Restart request, sampled while stopped |
| sys_clk_o | output | 1 | System clock, 33% duty |
| clk50_o | output | 1 | Companion clock, 50% duty, same frequency |
| pclk_o | output | 1 | Peripheral clock, half the system frequency |
| running_o | output | 1 | High while the clocks are active |

## Verification
The hardest states to reach are the rare transitions: a rate change landing on a period boundary, a halt code arriving in slow mode, and a start request arriving on the first reference edge after a stop. Directed segments cover each of these in turn: halt then restart in fast mode, a start request while running, a switch to slow mode, and a halt and restart in slow mode. After that, a long random phase toggles the rate at random moments and drives random status codes and start pulses. A halt code occurs often enough that stops and restarts repeat many times under both rates. The bench measures every pulse and period at half-cycle resolution. It computes the expected length from the rate select value recorded one edge before each rising edge.

// File: rtl/sclk_pkg.sv
`timescale 1ns/1ps
package sclk_pkg;
  localparam int unsigned PHASES = 3;
  typedef logic [1:0] phase_t;
  localparam logic [2:0] HALT_CODE = 3'b011;
  localparam phase_t PH_HIGH = 2'd0;
  localparam phase_t PH_MID  = 2'd1;
  localparam phase_t PH_LAST = 2'd2;
endpackage

// File: rtl/sclk_timebase.sv
`timescale 1ns/1ps
module sclk_timebase
  import sclk_pkg::*;
#(
  parameter int unsigned SLOW_STEPS = 256,
  localparam int unsigned SCW = (SLOW_STEPS > 1) ? $clog2(SLOW_STEPS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic           start_acc_i,
  input  logic           slow_sel_i,
  output phase_t         ph_o,
  output logic [SCW-1:0] sc_o,
  output logic           slow_o,
  output logic           at_zero_o,
  output logic           at_last_o
);
  phase_t         ph_q, ph_d;
  logic [SCW-1:0] sc_q, sc_d;
  logic           slow_q, slow_d;
  logic [SCW-1:0] sc_lim;
  logic           en;

  assign sc_lim    = slow_q ? SCW'(SLOW_STEPS - 1) : '0;
  assign at_zero_o = (ph_q == PH_HIGH) && (sc_q == '0);
  assign at_last_o = (ph_q == PH_LAST) && (sc_q == sc_lim);
  assign en        = run_i | start_acc_i;

  always_comb begin
    ph_d   = ph_q;
    sc_d   = sc_q;
    slow_d = slow_q;
    if (start_acc_i) begin
      slow_d = slow_sel_i;
    end else if (run_i) begin
      if (at_last_o) begin
        ph_d   = PH_HIGH;
        sc_d   = '0;
        slow_d = slow_sel_i;
      end else if (sc_q == sc_lim) begin
        ph_d = ph_q + 2'd1;
        sc_d = '0;
      end else begin
        sc_d = sc_q + SCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_HIGH;
      sc_q   <= '0;
      slow_q <= 1'b0;
    end else if (en) begin
      ph_q   <= ph_d;
      sc_q   <= sc_d;
      slow_q <= slow_d;
    end
  end

  assign ph_o   = ph_q;
  assign sc_o   = sc_q;
  assign slow_o = slow_q;
endmodule

// File: rtl/sclk_runctl.sv
`timescale 1ns/1ps
module sclk_runctl
  import sclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       at_zero_i,
  input  logic       at_last_i,
  input  logic [2:0] stat_i,
  input  logic       start_req_i,
  output logic       run_o,
  output logic       start_acc_o
);
  logic run_q, run_d;
  logic halt_q, halt_d;

  assign start_acc_o = !run_q && start_req_i;

  always_comb begin
    run_d  = run_q;
    halt_d = halt_q;
    if (run_q) begin
      if (at_zero_i) begin
        halt_d = (stat_i == HALT_CODE);
      end else if (at_last_i && halt_q) begin
        run_d  = 1'b0;
        halt_d = 1'b0;
      end
    end else if (start_req_i) begin
      run_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b1;
      halt_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      halt_q <= halt_d;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/sclk_outstage.sv
`timescale 1ns/1ps
module sclk_outstage
  import sclk_pkg::*;
#(
  parameter int unsigned SLOW_STEPS = 256,
  localparam int unsigned SCW = (SLOW_STEPS > 1) ? $clog2(SLOW_STEPS) : 1,
  localparam int unsigned HALF = SLOW_STEPS / 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  phase_t         ph_i,
  input  logic [SCW-1:0] sc_i,
  input  logic           slow_i,
  output logic           sys_o,
  output logic           c50_o,
  output logic           pclk_o
);
  logic sys_q, sys_d;
  logic c50_q, c50_d;
  logic pclk_q, pclk_d;
  logic ext_q;

  always_comb begin
    sys_d  = run_i && (ph_i == PH_HIGH);
    c50_d  = run_i && ((ph_i == PH_HIGH) ||
                       (slow_i && (ph_i == PH_MID) && (sc_i < SCW'(HALF))));
    pclk_d = pclk_q ^ (sys_q & ~sys_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q  <= 1'b0;
      c50_q  <= 1'b0;
      pclk_q <= 1'b0;
    end else begin
      sys_q  <= sys_d;
      c50_q  <= c50_d;
      pclk_q <= pclk_d;
    end
  end

  // Half-cycle extension of the fast-mode 50% clock.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= sys_q;
  end

  assign sys_o  = sys_q;
  assign c50_o  = slow_i ? c50_q : (c50_q | ext_q);
  assign pclk_o = pclk_q;
endmodule

// File: rtl/sclk_mode_ctrl.sv
`timescale 1ns/1ps
module sclk_mode_ctrl
  import sclk_pkg::*;
#(
  parameter int unsigned SLOW_STEPS = 256,
  localparam int unsigned SCW = (SLOW_STEPS > 1) ? $clog2(SLOW_STEPS) : 1
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       slow_sel,
  input  logic [2:0] stat_i,
  input  logic       start_req,
  output logic       sys_clk_o,
  output logic       clk50_o,
  output logic       pclk_o,
  output logic       running_o
);
  phase_t         ph;
  logic [SCW-1:0] sc;
  logic           slow_act, at_zero, at_last, run, start_acc;

  sclk_timebase #(.SLOW_STEPS(SLOW_STEPS)) tb_i (
    .clk(clk_ref), .rst_n(rst_n), .run_i(run), .start_acc_i(start_acc),
    .slow_sel_i(slow_sel), .ph_o(ph), .sc_o(sc), .slow_o(slow_act),
    .at_zero_o(at_zero), .at_last_o(at_last)
  );

  sclk_runctl rc_i (
    .clk(clk_ref), .rst_n(rst_n), .at_zero_i(at_zero), .at_last_i(at_last),
    .stat_i(stat_i), .start_req_i(start_req), .run_o(run),
    .start_acc_o(start_acc)
  );

  sclk_outstage #(.SLOW_STEPS(SLOW_STEPS)) os_i (
    .clk(clk_ref), .rst_n(rst_n), .run_i(run), .ph_i(ph), .sc_i(sc),
    .slow_i(slow_act), .sys_o(sys_clk_o), .c50_o(clk50_o), .pclk_o(pclk_o)
  );

  assign running_o = run;
endmodule

// File: rtl/sclk_mode_ctrl_chk.sv
`timescale 1ns/1ps
module sclk_mode_ctrl_chk (
  input logic clk_ref,
  input logic rst_n,
  input logic start_req,
  input logic sys_clk_o,
  input logic clk50_o,
  input logic pclk_o,
  input logic running_o,
  input logic slow_act
);
  a_r5_stopped_low: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !running_o |-> !sys_clk_o);
  a_r3_rise_aligned: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(sys_clk_o) |-> clk50_o);
  a_r3_covers_sys: assert property (@(posedge clk_ref) disable iff (!rst_n)
    sys_clk_o |-> clk50_o);
  a_r4_pclk_on_fall: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(pclk_o) |-> $fell(sys_clk_o));
  a_r4_fall_toggles: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(sys_clk_o) |-> !$stable(pclk_o));
  a_r1_fast_single: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (sys_clk_o && !slow_act) |=> !sys_clk_o);
  a_r7_start: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!running_o && start_req) |=> running_o);
  a_r7_rise_after_start: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!running_o && start_req) |=> ##1 sys_clk_o);
endmodule

bind sclk_mode_ctrl sclk_mode_ctrl_chk chk_i (
  .clk_ref(clk_ref), .rst_n(rst_n), .start_req(start_req),
  .sys_clk_o(sys_clk_o), .clk50_o(clk50_o), .pclk_o(pclk_o),
  .running_o(running_o), .slow_act(slow_act)
);

// File: tb/sclk_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module sclk_mode_ctrl_tb_top;
  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic       slow_sel;
  logic [2:0] stat_i;
  logic       start_req;
  logic       sys_clk_o, clk50_o, pclk_o, running_o;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         go = 0;
  bit         done = 0;

  always #10 clk_ref = ~clk_ref;

  sclk_mode_ctrl dut_i (
    .clk_ref(clk_ref), .rst_n(rst_n), .slow_sel(slow_sel), .stat_i(stat_i),
    .start_req(start_req), .sys_clk_o(sys_clk_o), .clk50_o(clk50_o),
    .pclk_o(pclk_o), .running_o(running_o)
  );

  // Expected values, in reference edges or half-cycle samples.
  function automatic int exp_edges(bit s);  return s ? 768 : 3; endfunction
  function automatic int exp_sys_hi(bit s); return s ? 512 : 2; endfunction
  function automatic int exp_c50_hi(bit s); return s ? 768 : 3; endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // Monitor: samples 5 ns after each clock edge.
  initial begin
    bit prev_sys = 0, prev_c50 = 0, prev_pclk = 0, prev_run = 1;
    bit sel_prev = 0, mode = 0, halt_armed = 0, tracking = 0, cont = 0, exp_rise = 0;
    int edge_cnt = 0, sys_hi = 0, c50_hi = 0;
    wait (go);
    forever begin
      for (int ph = 0; ph < 2; ph++) begin
        bit pos, rise;
        pos = (ph == 0);
        if (pos) @(posedge clk_ref); else @(negedge clk_ref);
        #5;
        rise = sys_clk_o && !prev_sys;
        if (pos) begin
          if (exp_rise) begin
            chk(rise, "R7 first rise after start", int'(sys_clk_o), 1);
            exp_rise = 0;
          end
          if (!prev_run && start_req) begin
            chk(running_o, "R7 start raises running", int'(running_o), 1);
            exp_rise = 1;
          end else if (!prev_run) begin
            chk(!running_o && !sys_clk_o, "R7 stays stopped", int'(running_o), 0);
          end
        end
        if (rise) begin
          chk(pos, "R1 rise on reference rising edge", int'(pos), 1);
          if (tracking && cont)
            chk(edge_cnt + 1 == exp_edges(mode), "R8 period length", edge_cnt + 1, exp_edges(mode));
          mode = sel_prev;
          halt_armed = (stat_i == 3'b011);
          edge_cnt = 0; sys_hi = 0; c50_hi = 0;
          tracking = 1; cont = 1;
          chk(clk50_o, "R3 aligned rise", int'(clk50_o), 1);
        end else if (pos && tracking) begin
          edge_cnt++;
          if (edge_cnt == exp_edges(mode) - 1) begin
            if (halt_armed) chk(!running_o, "R5 halt stops at period end", int'(running_o), 0);
            else            chk(running_o, "R6 non-halt keeps running", int'(running_o), 1);
            if (!running_o) begin tracking = 0; cont = 0; end
          end
          if (edge_cnt == exp_edges(mode))
            chk(0, "R1/R2 missing rise", edge_cnt, exp_edges(mode));
        end
        if (sys_clk_o) sys_hi++;
        if (clk50_o)   c50_hi++;
        if (prev_sys && !sys_clk_o) begin
          if (mode) chk(sys_hi == exp_sys_hi(1), "R2 slow high time", sys_hi, exp_sys_hi(1));
          else      chk(sys_hi == exp_sys_hi(0), "R1 fast high time", sys_hi, exp_sys_hi(0));
          chk(pclk_o != prev_pclk, "R4 toggle on fall", int'(pclk_o), int'(!prev_pclk));
        end else if (pclk_o != prev_pclk) begin
          chk(0, "R4 toggle without fall", int'(pclk_o), int'(prev_pclk));
        end
        if (prev_c50 && !clk50_o)
          chk(c50_hi == exp_c50_hi(mode), "R3 50pct high time", c50_hi, exp_c50_hi(mode));
        if (pos) begin sel_prev = slow_sel; prev_run = running_o; end
        prev_sys = sys_clk_o; prev_c50 = clk50_o; prev_pclk = pclk_o;
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_ref);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; slow_sel = 1'b0; stat_i = 3'b111; start_req = 1'b0;
    repeat (3) @(posedge clk_ref);
    #5;
    chk(!sys_clk_o, "R9 reset sys low", int'(sys_clk_o), 0);
    chk(!clk50_o,   "R9 reset c50 low", int'(clk50_o), 0);
    chk(!pclk_o,    "R9 reset pclk low", int'(pclk_o), 0);
    chk(running_o,  "R9 reset running", int'(running_o), 1);
    @(negedge clk_ref);
    rst_n = 1'b1; go = 1;
    idle(40);
    stat_i = 3'b011; idle(6); stat_i = 3'b111;          // R5 fast halt
    idle(20);
    start_req = 1'b1; idle(1); start_req = 1'b0;         // R7 restart
    idle(30);
    start_req = 1'b1; idle(3); start_req = 1'b0;         // R7 ignored while running
    idle(30);
    slow_sel = 1'b1; idle(2500);                          // R8 switch to slow
    stat_i = 3'b011; idle(800); stat_i = 3'b101; idle(900); // R5 slow halt
    start_req = 1'b1; idle(1); start_req = 1'b0; idle(1600);
    slow_sel = 1'b0; idle(1000);
    for (int i = 0; i < 30000; i++) begin
      logic [2:0] s;
      if ($urandom % 4000 == 0) slow_sel = ~slow_sel;
      s = 3'($urandom);
      if ($urandom % 24 == 0) s = 3'b011;
      else if (s == 3'b011) s = 3'b111;
      stat_i = s;
      start_req = ($urandom % 6 == 0);
      idle(1);
    end
    start_req = 1'b0; stat_i = 3'b111;
    idle(20);
    done = 1;
    finish_run();
  end
endmodule